// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Control

This block is the hazard control for a five-stage in-order integer pipeline with the stages fetch, decode/register read, execute/address calculation, memory access and writeback. Registers are read in decode and written in writeback. Every instruction passes through all five stages, so only read-after-write hazards arise. A read-after-write hazard exists when an instruction reads a register that an older instruction still in the pipe has not yet written back.

The unit compares register numbers across the stages. It returns a bypass select code for each of the two execute-stage ALU operands, so an ALU result reaches a dependent instruction without a stall. It also returns two stall controls. The first holds the PC and the fetch/decode register. The second turns the decode/execute register into a no-op for the next cycle.

Two situations still stall the pipe. A load followed directly by an instruction that reads the loaded register costs one stall cycle, because the loaded value is not ready in time even with bypassing. A data access in the memory stage occupies the single shared instruction/data memory port, so fetch has to wait one cycle. The unit is purely combinational, so every result belongs to the inputs of the same cycle.

Top module: `hazard_unit`

## Requirements
- R1: An operand's select is 2'b01 (memory-stage bypass) when the memory-stage instruction writes a nonzero register equal to that operand's execute-stage source.
- R2: An operand's select is 2'b10 (writeback-stage bypass) when the writeback-stage instruction writes a nonzero register equal to the source and the memory stage does not match it.
- R3: When both the memory and writeback stages write the source register, the select is 2'b01, because the younger value wins.
- R4: Register 0 is never bypassed and never causes a load-use stall. A source of 0 always gives select 2'b00.
- R5: A producer whose write-enable is low is ignored. With no valid matching producer, the select is 2'b00 (register file).
- R6: `holdFront` is high when the execute-stage instruction is a load that writes a nonzero register equal to either decode-stage source.
- R7: `holdFront` is high whenever the memory-stage instruction is a load or a store, because that access takes the shared memory port.
- R8: `bubbleEx` equals `holdFront` in every cycle, and `holdFront` is low when neither condition of R6 or R7 holds.
- R9: A non-load instruction in execute that writes a decode-stage source does not cause a stall.
- R10: The two operands are resolved independently. Each select depends only on its own source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| decSrcA | input | 5 | First source register of the decode-stage instruction |
| decSrcB | input | 5 | Second source register of the decode-stage instruction |
| exSrcA | input | 5 | First source register of the execute-stage instruction |
| exSrcB | input | 5 | Second source register of the execute-stage instruction |
| exDst | input | 5 | Destination register of the execute-stage instruction |
| exWrite | input | 1 | Execute-stage instruction writes a register |
| exLoad | input | 1 | Execute-stage instruction is a load |
| memDst | input | 5 | Destination register of the memory-stage instruction |
| memWrite | input | 1 | Memory-stage instruction writes a register |
| memLoad | input | 1 | Memory-stage instruction reads data memory |
| memStore | input | 1 | Memory-stage instruction writes data memory |
| wbDst | input | 5 | Destination register of the writeback-stage instruction |
| wbWrite | input | 1 | Writeback-stage instruction writes a register |
| selA | output | 2 | Bypass select for ALU operand A (00 file, 01 memory, 10 writeback) |
| selB | output | 2 | Bypass select for ALU operand B (same coding) |
| holdFront | output | 1 | Hold the PC and the fetch/decode register |
| bubbleEx | output | 1 | Load a no-op into the decode/execute register |

## Verification
Every output is a combinational function of the inputs present in the same cycle, so each result is due in the cycle its stimulus is applied, with zero register delay. The bench applies stimulus just after a rising edge and compares all four outputs with its model at the following falling edge, after the inputs have settled and well before the next edge. Directed vectors cover each priority and exclusion case. A long stream of random vectors follows, drawn from a small set of register numbers so that matches, register 0 and overlapping producers occur often.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwdSrc_e;

  // strobes from control to the bypass datapath
  typedef struct packed {
    logic memProducer;
    logic wbProducer;
  } hzStrobe_t;

endpackage

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [REG_AW-1:0] decSrc [NUM_SRC],
  input  logic [REG_AW-1:0] exDst,
  input  logic              exWrite,
  input  logic              exLoad,
  input  logic [REG_AW-1:0] memDst,
  input  logic              memWrite,
  input  logic              memLoad,
  input  logic              memStore,
  input  logic [REG_AW-1:0] wbDst,
  input  logic              wbWrite,
  output hzStrobe_t         strobe,
  output logic              stallReq
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic             loadProducer;
  logic [NUM_SRC-1:0] srcHit;
  logic             loadUse;
  logic             portBusy;

  assign loadProducer = exLoad && exWrite && (exDst != ZERO_REG);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign srcHit[s] = loadProducer && (decSrc[s] == exDst);
  end

  assign loadUse  = |srcHit;
  assign portBusy = memLoad || memStore;
  assign stallReq = loadUse || portBusy;

  always_comb begin
    strobe             = '0;
    strobe.memProducer = memWrite && (memDst != ZERO_REG);
    strobe.wbProducer  = wbWrite && (wbDst != ZERO_REG);
  end

endmodule

// File: rtl/hazard_bypass.sv
module hazard_bypass
  import hazard_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [REG_AW-1:0] exSrc [NUM_SRC],
  input  logic [REG_AW-1:0] memDst,
  input  logic [REG_AW-1:0] wbDst,
  input  hzStrobe_t         strobe,
  output fwdSrc_e           sel [NUM_SRC]
);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_op
    logic memMatch;
    logic wbMatch;
    assign memMatch = strobe.memProducer && (exSrc[s] == memDst);
    assign wbMatch  = strobe.wbProducer && (exSrc[s] == wbDst);
    always_comb begin
      if (memMatch)     sel[s] = FWD_MEM;
      else if (wbMatch) sel[s] = FWD_WB;
      else              sel[s] = FWD_RF;
    end
  end

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] decSrcA,
  input  logic [REG_AW-1:0] decSrcB,
  input  logic [REG_AW-1:0] exSrcA,
  input  logic [REG_AW-1:0] exSrcB,
  input  logic [REG_AW-1:0] exDst,
  input  logic              exWrite,
  input  logic              exLoad,
  input  logic [REG_AW-1:0] memDst,
  input  logic              memWrite,
  input  logic              memLoad,
  input  logic              memStore,
  input  logic [REG_AW-1:0] wbDst,
  input  logic              wbWrite,
  output logic [1:0]        selA,
  output logic [1:0]        selB,
  output logic              holdFront,
  output logic              bubbleEx
);

  localparam int NUM_SRC = 2;

  logic [REG_AW-1:0] decSrc [NUM_SRC];
  logic [REG_AW-1:0] exSrc  [NUM_SRC];
  fwdSrc_e           sel    [NUM_SRC];
  hzStrobe_t         strobe;
  logic              stallReq;

  assign decSrc[0] = decSrcA;
  assign decSrc[1] = decSrcB;
  assign exSrc[0]  = exSrcA;
  assign exSrc[1]  = exSrcB;

  hazard_ctrl #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_ctrl (
    .decSrc   (decSrc),
    .exDst    (exDst),
    .exWrite  (exWrite),
    .exLoad   (exLoad),
    .memDst   (memDst),
    .memWrite (memWrite),
    .memLoad  (memLoad),
    .memStore (memStore),
    .wbDst    (wbDst),
    .wbWrite  (wbWrite),
    .strobe   (strobe),
    .stallReq (stallReq)
  );

  hazard_bypass #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_bypass (
    .exSrc  (exSrc),
    .memDst (memDst),
    .wbDst  (wbDst),
    .strobe (strobe),
    .sel    (sel)
  );

  assign selA      = sel[0];
  assign selB      = sel[1];
  assign holdFront = stallReq;
  assign bubbleEx  = stallReq;

endmodule

// File: rtl/hazard_checker.sv
module hazard_checker #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] decSrcA,
  input logic [REG_AW-1:0] decSrcB,
  input logic [REG_AW-1:0] exSrcA,
  input logic [REG_AW-1:0] exSrcB,
  input logic [REG_AW-1:0] exDst,
  input logic              exWrite,
  input logic              exLoad,
  input logic [REG_AW-1:0] memDst,
  input logic              memWrite,
  input logic              memLoad,
  input logic              memStore,
  input logic [REG_AW-1:0] wbDst,
  input logic              wbWrite,
  input logic [1:0]        selA,
  input logic [1:0]        selB,
  input logic              holdFront,
  input logic              bubbleEx
);

  always_comb begin
    // R3: a memory-stage match always wins
    p_mem_wins_r3: assert (!(memWrite && memDst != '0 && memDst == exSrcA) || selA == 2'b01);
    // R2: writeback bypass only when the memory stage has no match
    p_wb_only_r2: assert (!(selA == 2'b10) || (wbWrite && wbDst == exSrcA && !(memWrite && memDst == exSrcA)));
    // R4: register 0 is never bypassed
    p_zero_src_r4: assert (!(exSrcB == '0) || selB == 2'b00);
    // R5: the select is never the unused code 2'b11
    p_code_legal_r5: assert (selA != 2'b11 && selB != 2'b11);
    // R7: a memory-stage access always holds fetch
    p_port_busy_r7: assert (!(memLoad || memStore) || holdFront);
    // R6: a load-use match always holds the front end
    p_load_use_r6: assert (!(exLoad && exWrite && exDst != '0 && (exDst == decSrcA || exDst == decSrcB)) || holdFront);
    // R8: bubble and hold go together
    p_bubble_r8: assert (bubbleEx == holdFront);
  end

endmodule

bind hazard_unit hazard_checker #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/tb_hazard_unit.sv
module tb_hazard_unit;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] decSrcA, decSrcB, exSrcA, exSrcB, exDst, memDst, wbDst;
  logic exWrite, exLoad, memWrite, memLoad, memStore, wbWrite;
  logic [1:0] selA, selB;
  logic holdFront, bubbleEx;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  hazard_unit dut (.*);

  // behavioural model: producers listed youngest first
  function automatic logic [1:0] refSel(input logic [4:0] src);
    logic [4:0] dsts [$];
    logic       wes  [$];
    logic [1:0] codes [$];
    dsts = '{memDst, wbDst};
    wes = '{memWrite, wbWrite};
    codes = '{2'b01, 2'b10};
    if (src == 0) return 2'b00;
    foreach (dsts[i]) if (wes[i] && dsts[i] == src) return codes[i];
    return 2'b00;
  endfunction

  function automatic logic refStall();
    logic lu;
    lu = exLoad && exWrite && exDst != 0 && (exDst == decSrcA || exDst == decSrcB);
    return lu || memLoad || memStore;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "selA", selA, refSel(exSrcA));
    chk(tag, "selB", selB, refSel(exSrcB));
    chk(tag, "holdFront", holdFront, refStall());
    chk(tag, "bubbleEx", bubbleEx, refStall());
  endtask

  task automatic idle();
    decSrcA = 0; decSrcB = 0; exSrcA = 0; exSrcB = 0;
    exDst = 0; exWrite = 0; exLoad = 0;
    memDst = 0; memWrite = 0; memLoad = 0; memStore = 0;
    wbDst = 0; wbWrite = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    idle();
    step();
    chk("R5", "idle selA", selA, 0);
    chk("R8", "idle hold", holdFront, 0);

    // R1 memory-stage bypass on A
    @(posedge clk); idle(); exSrcA = 3; memDst = 3; memWrite = 1;
    step(); chk("R1", "selA mem", selA, 1); chk("R10", "selB untouched", selB, 0);

    // R2 writeback bypass on B
    @(posedge clk); idle(); exSrcB = 7; wbDst = 7; wbWrite = 1;
    step(); chk("R2", "selB wb", selB, 2); chk("R10", "selA untouched", selA, 0);

    // R3 both stages write the same register
    @(posedge clk); idle(); exSrcA = 9; memDst = 9; memWrite = 1; wbDst = 9; wbWrite = 1;
    step(); chk("R3", "selA priority", selA, 1);

    // R4 register 0 as producer and source
    @(posedge clk); idle(); memWrite = 1; wbWrite = 1; exLoad = 1; exWrite = 1;
    step(); chk("R4", "selA r0", selA, 0); chk("R4", "selB r0", selB, 0);
    chk("R4", "no stall r0", holdFront, 0);

    // R5 write-enable low
    @(posedge clk); idle(); exSrcA = 4; memDst = 4; wbDst = 4;
    step(); chk("R5", "selA no we", selA, 0);

    // R6 load-use on each decode source
    @(posedge clk); idle(); exLoad = 1; exWrite = 1; exDst = 5; decSrcB = 5;
    step(); chk("R6", "hold srcB", holdFront, 1); chk("R8", "bubble", bubbleEx, 1);
    @(posedge clk); idle(); exLoad = 1; exWrite = 1; exDst = 6; decSrcA = 6;
    step(); chk("R6", "hold srcA", holdFront, 1);

    // R9 ALU producer in execute does not stall
    @(posedge clk); idle(); exWrite = 1; exDst = 6; decSrcA = 6;
    step(); chk("R9", "no stall alu", holdFront, 0); chk("R8", "no bubble", bubbleEx, 0);

    // R7 structural stall for load and store
    @(posedge clk); idle(); memLoad = 1;
    step(); chk("R7", "hold load", holdFront, 1);
    @(posedge clk); idle(); memStore = 1;
    step(); chk("R7", "hold store", holdFront, 1); chk("R8", "bubble store", bubbleEx, 1);

    // R10 random stream with a narrow register range
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk);
      decSrcA = 5'($urandom_range(0, 3)); decSrcB = 5'($urandom_range(0, 3));
      exSrcA  = 5'($urandom_range(0, 3)); exSrcB  = 5'($urandom_range(0, 3));
      exDst   = 5'($urandom_range(0, 3)); memDst  = 5'($urandom_range(0, 3));
      wbDst   = 5'($urandom_range(0, 3));
      exWrite = 1'($urandom); exLoad = 1'($urandom);
      memWrite = 1'($urandom); wbWrite = 1'($urandom);
      memLoad = ($urandom_range(0, 3) == 0); memStore = ($urandom_range(0, 3) == 0);
      step();
      checkAll("R10");
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule